// File: doc/BRIEF.md
# Bidirectional Step-Based Instruction Sequencer

This block produces the fetch address for a reversible processor. Two registers carry the control flow: a program counter and a signed step. After each executed instruction the counter advances by the step, plus one extra halfword when that instruction has an extension halfword. Jumps never load the counter. When its condition holds, a jump adds a signed delta to the step, so control keeps moving with the new stride until a matching jump of opposite delta at the target restores it.

The same block runs programs backwards. A reverse move takes two presentations. First the instruction at the current address is shown. Its flag saying whether its physical predecessor was extended lets the counter retreat by the step plus that predecessor's extra halfword. Next the instruction found at the new address is shown, and its effect on the step is undone: if it is a jump whose condition holds, its delta is subtracted. The surrounding core fetches both halfwords at `pc_o` and `pc_o + 2`. It also supplies the two register values that a conditional jump compares. The `undo_o` output tells the core which of the two reverse presentations is expected.

Top module: `bidir_step_seq`

## Requirements
- R1: A synchronous active-high reset sets `pc_o` to 0 and `step_o` to 2, and clears `undo_o`.
- R2: Instruction halfword layout: bits [15:10] hold the opcode, and opcode bit 5 (value 0x20) marks an extended instruction. Bit 9 flags that the preceding instruction in memory was extended. Bits [8:0] do not affect sequencing. The second halfword of a jump carries its signed 16-bit delta.
- R3: In forward mode, an instruction that is not a jump leaves the step unchanged. The PC becomes PC + step + 2 if the instruction is extended, or PC + step otherwise.
- R4: Opcodes 0x30 (equal), 0x31 (not equal), 0x32 (less), 0x33 (greater), 0x34 (less or equal) and 0x35 (greater or equal) compare `opa_i` with `opb_i` as signed 16-bit values. In forward mode, when the condition holds, the delta is added to the step first, and the PC then advances by the new step + 2.
- R5: Opcode 0x36 always adds its delta to the step. Opcodes 0x37 to 0x3F never change the step.
- R6: A reverse request with `undo_o` low leaves the step unchanged. It sets the PC to PC − step − (2 if bit 9 of the presented halfword is set, else 0) and raises `undo_o` for the next presentation.
- R7: With `undo_o` high, a valid presentation leaves the PC unchanged and clears `undo_o`, whatever the direction input. If the presented instruction is a jump whose condition holds, its delta is subtracted from the step.
- R8: While `valid_i` is low, the PC, the step and `undo_o` hold their values.
- R9: PC and step arithmetic wraps modulo 2^16.
- R10: Running a program forward and then in reverse over the same number of instructions returns the PC and the step to their starting values. This holds when the jumps are paired by opposite deltas and each jump target's bit 9 describes the jump source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | An instruction is presented this cycle |
| reverse_i | input | 1 | 1 requests a reverse move, 0 a forward one |
| hw0_i | input | 16 | First instruction halfword, fetched at `pc_o` |
| hw1_i | input | 16 | Extension halfword, fetched at `pc_o + 2` (jump delta) |
| opa_i | input | 16 | First compared register value |
| opb_i | input | 16 | Second compared register value |
| pc_o | output | 16 | Current fetch address |
| step_o | output | 16 | Current signed step |
| undo_o | output | 1 | Next presentation is the undo phase of a reverse move |

## Verification
Each of the seven jump opcodes is tried with operand pairs that are equal, ordered each way and of opposite sign. Opposite-sign pairs separate a signed comparison from an unsigned one. Presenting the same patterns in the forward and in the undo phase shows that the delta is added in one and subtracted in the other. Non-jump opcodes, with and without the extension bit, show that the extra halfword is counted only when extended. Reverse requests with bit 9 clear and set show that the retreat follows the predecessor flag rather than the instruction's own extension. A short program with a paired jump and its skipped body is run forward and then backward and must return to address 0 with step 2. A large jump delta drives the PC across the 16-bit boundary to exercise wrapping.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int DW         = 16;
    localparam int HW_BYTES   = 2;
    localparam int RESET_STEP = 2;

    localparam int OPC_MSB    = 15;
    localparam int OPC_LSB    = 10;
    localparam int OPC_W      = OPC_MSB - OPC_LSB + 1;
    localparam int PREV_BIT   = 9;
    localparam int EXT_BIT    = OPC_W - 1;

    localparam logic [OPC_W-1:0] OPC_JUMP_BASE = 6'h30;
    localparam logic [OPC_W-1:0] OPC_JUMP_LAST = 6'h36;

    typedef enum logic [2:0] {
        CMP_EQ     = 3'd0,
        CMP_NE     = 3'd1,
        CMP_LT     = 3'd2,
        CMP_GT     = 3'd3,
        CMP_LE     = 3'd4,
        CMP_GE     = 3'd5,
        CMP_ALWAYS = 3'd6,
        CMP_NONE   = 3'd7
    } cmp_e;

    typedef struct packed {
        logic             ext;
        logic             prev_ext;
        cmp_e             cmp;
        logic [OPC_W-1:0] opcode;
    } dec_t;

    function automatic cmp_e opcode_to_cmp(input logic [OPC_W-1:0] opc);
        cmp_e c;
        if (opc >= OPC_JUMP_BASE && opc <= OPC_JUMP_LAST) begin
            c = cmp_e'(3'(opc - OPC_JUMP_BASE));
        end else begin
            c = CMP_NONE;
        end
        return c;
    endfunction

    function automatic logic cond_holds(input cmp_e c,
                                        input logic signed [DW-1:0] a,
                                        input logic signed [DW-1:0] b);
        logic r;
        unique case (c)
            CMP_EQ:     r = (a == b);
            CMP_NE:     r = (a != b);
            CMP_LT:     r = (a <  b);
            CMP_GT:     r = (a >  b);
            CMP_LE:     r = (a <= b);
            CMP_GE:     r = (a >= b);
            CMP_ALWAYS: r = 1'b1;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic [DW-1:0] hw_i,
    output dec_t          dec_o
);
    logic [OPC_W-1:0] opc;
    logic             unused_fields;

    assign opc           = hw_i[OPC_MSB:OPC_LSB];
    assign unused_fields = ^hw_i[PREV_BIT-1:0];

    always_comb begin
        dec_o.opcode   = opc;
        dec_o.ext      = opc[EXT_BIT];
        dec_o.prev_ext = hw_i[PREV_BIT];
        dec_o.cmp      = opcode_to_cmp(opc);
    end

    // R5: only the jump window may yield a comparison code other than none
    always_comb begin
        if (!(opc >= OPC_JUMP_BASE && opc <= OPC_JUMP_LAST))
            a_r5_nonjump_none: assert (dec_o.cmp == CMP_NONE || $isunknown(opc));
    end
endmodule

// File: rtl/seq_branch.sv
module seq_branch
    import seq_pkg::*;
(
    input  cmp_e          cmp_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic          taken_o
);
    assign taken_o = cond_holds(cmp_i, $signed(a_i), $signed(b_i));

    // R5: the unconditional code is always taken, the none code never
    always_comb begin
        if (cmp_i == CMP_ALWAYS) a_r5_always_taken: assert (taken_o);
        if (cmp_i == CMP_NONE)   a_r5_none_idle:    assert (!taken_o);
    end
endmodule

// File: rtl/seq_step_unit.sv
module seq_step_unit
    import seq_pkg::*;
#(
    parameter int W     = DW,
    parameter int RST_V = RESET_STEP
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fwd_en,
    input  logic         undo_en,
    input  logic         taken,
    input  logic [W-1:0] delta,
    output logic [W-1:0] step_q,
    output logic [W-1:0] step_fwd
);
    assign step_fwd = taken ? step_q + delta : step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= W'(RST_V);
        end else if (fwd_en) begin
            step_q <= step_fwd;
        end else if (undo_en && taken) begin
            step_q <= step_q - delta;
        end
    end

    a_r8_step_idle: assert property (@(posedge clk) disable iff (rst)
        (!fwd_en && !undo_en) |=> $stable(step_q));

    a_r3_step_untaken: assert property (@(posedge clk) disable iff (rst)
        (fwd_en && !taken) |=> $stable(step_q));

    a_r7_undo_inverse: assert property (@(posedge clk) disable iff (rst)
        (undo_en && taken) |=> (W'(step_q + $past(delta)) == $past(step_q)));

    a_r4_fwd_sum: assert property (@(posedge clk) disable iff (rst)
        (fwd_en && taken) |=> (W'(step_q - $past(delta)) == $past(step_q)));
endmodule

// File: rtl/seq_pc_unit.sv
module seq_pc_unit
    import seq_pkg::*;
#(
    parameter int W  = DW,
    parameter int HB = HW_BYTES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fwd_en,
    input  logic         back_en,
    input  logic         ext,
    input  logic         prev_ext,
    input  logic [W-1:0] step_fwd,
    input  logic [W-1:0] step_cur,
    output logic [W-1:0] pc_q
);
    localparam logic [W-1:0] EXTRA = W'(HB);

    logic [W-1:0] fwd_gap;
    logic [W-1:0] back_gap;

    assign fwd_gap  = step_fwd + (ext      ? EXTRA : '0);
    assign back_gap = step_cur + (prev_ext ? EXTRA : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (fwd_en) begin
            pc_q <= pc_q + fwd_gap;
        end else if (back_en) begin
            pc_q <= pc_q - back_gap;
        end
    end

    a_r8_pc_idle: assert property (@(posedge clk) disable iff (rst)
        (!fwd_en && !back_en) |=> $stable(pc_q));

    a_r6_back_plain: assert property (@(posedge clk) disable iff (rst)
        (back_en && !prev_ext) |=> (W'(pc_q + $past(step_cur)) == $past(pc_q)));
endmodule

// File: rtl/bidir_step_seq.sv
module bidir_step_seq
    import seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_i,
    input  logic          reverse_i,
    input  logic [DW-1:0] hw0_i,
    input  logic [DW-1:0] hw1_i,
    input  logic [DW-1:0] opa_i,
    input  logic [DW-1:0] opb_i,
    output logic [DW-1:0] pc_o,
    output logic [DW-1:0] step_o,
    output logic          undo_o
);
    dec_t          dec;
    logic          taken;
    logic          undo_q;
    logic          fwd_en;
    logic          back_en;
    logic          undo_en;
    logic [DW-1:0] step_q;
    logic [DW-1:0] step_fwd;

    assign fwd_en  = valid_i && !undo_q && !reverse_i;
    assign back_en = valid_i && !undo_q &&  reverse_i;
    assign undo_en = valid_i &&  undo_q;

    seq_decode u_dec (
        .hw_i  (hw0_i),
        .dec_o (dec)
    );

    seq_branch u_br (
        .cmp_i   (dec.cmp),
        .a_i     (opa_i),
        .b_i     (opb_i),
        .taken_o (taken)
    );

    seq_step_unit #(.W(DW), .RST_V(RESET_STEP)) u_step (
        .clk      (clk),
        .rst      (rst),
        .fwd_en   (fwd_en),
        .undo_en  (undo_en),
        .taken    (taken),
        .delta    (hw1_i),
        .step_q   (step_q),
        .step_fwd (step_fwd)
    );

    seq_pc_unit #(.W(DW), .HB(HW_BYTES)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .fwd_en   (fwd_en),
        .back_en  (back_en),
        .ext      (dec.ext),
        .prev_ext (dec.prev_ext),
        .step_fwd (step_fwd),
        .step_cur (step_q),
        .pc_q     (pc_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            undo_q <= 1'b0;
        end else if (back_en) begin
            undo_q <= 1'b1;
        end else if (undo_en) begin
            undo_q <= 1'b0;
        end
    end

    assign step_o = step_q;
    assign undo_o = undo_q;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pc_o == '0 && step_o == DW'(RESET_STEP) && !undo_o));

    a_r6_undo_armed: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !undo_o && reverse_i) |=> (undo_o && $stable(step_o)));

    a_r7_undo_once: assert property (@(posedge clk) disable iff (rst)
        (valid_i && undo_o) |=> (!undo_o && $stable(pc_o)));

    a_r8_undo_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(undo_o));
endmodule

// File: tb/bidir_step_seq_bench.sv
`timescale 1ns/1ps
module bidir_step_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic        reverse_i = 1'b0;
    logic [15:0] hw0_i = '0;
    logic [15:0] hw1_i = '0;
    logic [15:0] opa_i = '0;
    logic [15:0] opb_i = '0;
    logic [15:0] pc_o;
    logic [15:0] step_o;
    logic        undo_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    int m_pc, m_step, m_undo;
    string m_tag;

    logic [15:0] prog [0:15];

    always #4 clk = ~clk;

    bidir_step_seq u_bidir_step_seq (
        .clk(clk), .rst(rst), .valid_i(valid_i), .reverse_i(reverse_i),
        .hw0_i(hw0_i), .hw1_i(hw1_i), .opa_i(opa_i), .opb_i(opb_i),
        .pc_o(pc_o), .step_o(step_o), .undo_o(undo_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int sx(input int v);
        return (v >= 32768) ? v - 65536 : v;
    endfunction

    function automatic bit holds(input int op, input int a, input int b);
        int x = sx(a);
        int y = sx(b);
        case (op)
            'h30: return x == y;
            'h31: return x != y;
            'h32: return x <  y;
            'h33: return x >  y;
            'h34: return x <= y;
            'h35: return x >= y;
            'h36: return 1;
            default: return 0;
        endcase
    endfunction

    task automatic model_update();
        int op  = (int'(hw0_i) >> 10) & 63;
        int ext = (op >> 5) & 1;
        int pv  = (int'(hw0_i) >> 9) & 1;
        bit t   = holds(op, int'(opa_i), int'(opb_i));
        int d   = int'(hw1_i);
        if (!valid_i) begin
            m_tag = "R8";
        end else if (m_undo != 0) begin
            m_tag = "R7";
            if (t) m_step = (m_step - d) & 16'hFFFF;
            m_undo = 0;
        end else if (reverse_i) begin
            m_tag = "R6";
            m_pc = (m_pc - m_step - 2 * pv) & 16'hFFFF;
            m_undo = 1;
        end else begin
            m_tag = (op == 'h36) ? "R5" : ((op >= 'h30 && op <= 'h35) ? "R4" : "R3");
            if (t) m_step = (m_step + d) & 16'hFFFF;
            m_pc = (m_pc + m_step + 2 * ext) & 16'hFFFF;
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (int'(pc_o) != m_pc || int'(step_o) != m_step || int'(undo_o) != m_undo) begin
            errors++;
            $display("FAIL %s actual pc=%h step=%h undo=%0d expected pc=%h step=%h undo=%0d",
                     tag, pc_o, step_o, undo_o, m_pc[15:0], m_step[15:0], m_undo);
        end
    endtask

    task automatic run(input bit v, input bit rv, input logic [15:0] h0,
                       input logic [15:0] h1, input logic [15:0] a,
                       input logic [15:0] b, input string extra);
        valid_i = v; reverse_i = rv; hw0_i = h0; hw1_i = h1; opa_i = a; opb_i = b;
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare({m_tag, extra});
    endtask

    task automatic do_reset();
        rst = 1'b1; valid_i = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pc = 0; m_step = 2; m_undo = 0;
        checks++;
        if (pc_o !== 16'h0 || step_o !== 16'h2 || undo_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 actual pc=%h step=%h undo=%b expected pc=0000 step=0002 undo=0",
                     pc_o, step_o, undo_o);
        end
    endtask

    task automatic run_prog(input bit rv);
        int a = int'(pc_o) >> 1;
        run(1'b1, rv, prog[a & 15], prog[(a + 1) & 15], 16'h0, 16'h0, " R2 prog");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) prog[i] = 16'h0000;
        prog[0]  = 16'h84F3; prog[1]  = 16'h0005;   // extended non-jump, noise in [8:0]
        prog[2]  = 16'hDA00; prog[3]  = 16'h0004;   // unconditional +4, predecessor extended
        prog[4]  = 16'h8600; prog[5]  = 16'h0009;   // skipped body
        prog[6]  = 16'hDA00; prog[7]  = 16'hFFFC;   // unconditional -4, flag describes source
        prog[8]  = 16'h0200;                        // short, predecessor extended
        prog[9]  = 16'h0C00;                        // short
        prog[10] = 16'h0000;

        @(negedge clk);
        do_reset();

        // R2 R3 R4 R5 R10: paired-jump program, forward then reverse
        for (int k = 0; k < 5; k++) run_prog(1'b0);
        checks++;
        if (pc_o !== 16'd20 || step_o !== 16'd2) begin
            errors++;
            $display("FAIL R5 actual pc=%h step=%h expected pc=0014 step=0002", pc_o, step_o);
        end
        for (int k = 0; k < 10; k++) run_prog(1'b1);
        checks++;
        if (pc_o !== 16'h0 || step_o !== 16'h2 || undo_o !== 1'b0) begin
            errors++;
            $display("FAIL R10 actual pc=%h step=%h undo=%b expected pc=0000 step=0002 undo=0",
                     pc_o, step_o, undo_o);
        end

        // R4: signed comparisons, opposite-sign operands, forward and undo
        do_reset();
        for (int op = 'h30; op <= 'h37; op++) begin
            run(1'b1, 1'b0, 16'(op << 10), 16'h0010, 16'hFFFF, 16'h0001, " R4 neg-pos");
            run(1'b1, 1'b0, 16'(op << 10), 16'h0006, 16'h0001, 16'hFFFF, " R4 pos-neg");
            run(1'b1, 1'b0, 16'(op << 10), 16'hFFF8, 16'h1234, 16'h1234, " R4 equal");
            run(1'b1, 1'b1, 16'h0200,      16'h0000, 16'h0, 16'h0, " R6 flag set");
            run(1'b1, 1'b0, 16'(op << 10), 16'h0010, 16'h8000, 16'h7FFF, " R7 dir ignored");
        end

        // R8: idle presentations carry a taken jump that must not act
        run(1'b0, 1'b0, 16'hD800, 16'h0100, 16'h0, 16'h0, " R8 idle fwd");
        run(1'b1, 1'b1, 16'h0000, 16'h0000, 16'h0, 16'h0, " R6 flag clear");
        run(1'b0, 1'b1, 16'hD800, 16'h0100, 16'h0, 16'h0, " R8 idle undo");
        run(1'b1, 1'b1, 16'hD800, 16'h0100, 16'h0, 16'h0, " R7 undo jmp");

        // R9: wrap of PC and step
        do_reset();
        run(1'b1, 1'b0, 16'hD800, 16'h7FF0, 16'h0, 16'h0, " R9 big delta");
        run(1'b1, 1'b0, 16'h0000, 16'h0000, 16'h0, 16'h0, " R9 pc wrap");
        run(1'b1, 1'b0, 16'h0000, 16'h0000, 16'h0, 16'h0, " R9 pc wrap");
        run(1'b1, 1'b0, 16'hD800, 16'h7FF0, 16'h0, 16'h0, " R9 step wrap");
        run(1'b1, 1'b1, 16'h0000, 16'h0000, 16'h0, 16'h0, " R9 back wrap");
        run(1'b1, 1'b0, 16'h0000, 16'h0000, 16'h0, 16'h0, " R9 undo");

        // R3 R4 R5 R6 R7 R8: mixed random traffic against the model
        do_reset();
        for (int n = 0; n < 600; n++) begin
            int r = int'($urandom);
            logic [5:0] op = (r % 3 == 0) ? 6'(6'h30 + ((r >> 4) % 8)) : 6'($urandom);
            logic [15:0] h0 = {op, 10'($urandom)};
            logic [15:0] av = 16'($urandom);
            logic [15:0] bv = ((r >> 8) % 4 == 0) ? av : 16'($urandom);
            run(((r >> 12) % 10) != 0, ((r >> 16) % 2) == 1, h0, 16'($urandom), av, bv, " rand");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule